// File: doc/BRIEF.md
# Candidate-Vector Block Matcher

This block picks a motion vector for one 16x16 luminance macroblock by trying a short list of five candidate vectors. Each candidate is given in half-pel units. For each candidate in range, the block forms the predicted macroblock from a local window cache that holds part of the previous decoded frame. It sums the absolute differences against the current macroblock and keeps the candidate with the lowest sum. Only these few candidates are matched. No exhaustive search over the window takes place.

A controller places the five candidates on the candidate buses and pulses `start`. The block captures the list and then walks the macroblock one pixel per cycle for each candidate in range. It reads the current pixel through a combinational read port. It reads the 2x2 reference neighbourhood through a combinational quad read port on the window cache. When the last candidate has finished, the block raises `done` for one cycle. The chosen vector and its SAD stay on the outputs until the next search completes. All pins are plain control or data pins. The read ports answer in the same cycle, so no valid/ready handshake is needed and no back-pressure can occur.

Top module: `cand_block_matcher`

## Requirements
- R1: Each search evaluates the five candidates in list order. `best_dy`/`best_dx` report the in-range candidate with the smallest sum of absolute differences over all 256 pixels, and `best_sad` reports that sum.
- R2: A vector is in range when its half-pel vertical part lies in -12..+12 and its half-pel horizontal part lies in -16..+14. A candidate out of range is skipped and can never be reported.
- R3: When all five candidates are out of range, the zero vector is evaluated and reported together with its SAD.
- R4: When several in-range candidates share the minimum SAD, the one earliest in the list is reported.
- R5: The vector's bit 0 selects a half-pel phase: dy bit 0 selects vertical and dx bit 0 selects horizontal. With both phases, the sample is (p00+p01+p10+p11+2)>>2. With one phase, it is the rounded-up mean of the two pixels on that axis. With no phase, it is p00.
- R6: `done` is high for exactly one cycle, in the cycle after the last candidate completes. The result outputs change only at the end of a candidate's evaluation.
- R7: After reset, `done` is low and `best_dy`, `best_dx` and `best_sad` are zero.
- R8: For pixel (py,px) and vector (dy,dx), the cache row is py + floor(dy/2) + 6 and the cache column is px + floor(dx/2) + 8. p01 is one column to the right of p00, p10 is one row below, and p11 is diagonal to it.
- R9: The candidate list is captured on `start`. While a search is running, `start` and any change on the candidate buses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search with the present candidate list (used only when idle) |
| cand_dy | input | 30 | Five signed 6-bit vertical half-pel components, candidate i at bits 6i+5:6i |
| cand_dx | input | 30 | Five signed 6-bit horizontal half-pel components, same packing |
| cur_row | output | 4 | Row of the current-macroblock pixel being read |
| cur_col | output | 4 | Column of the current-macroblock pixel being read |
| cur_pix | input | 8 | Current-macroblock pixel at (cur_row, cur_col) |
| win_row | output | 5 | Window cache row of p00 |
| win_col | output | 5 | Window cache column of p00 |
| win_p00 | input | 8 | Cache pixel at (win_row, win_col) |
| win_p01 | input | 8 | Cache pixel at (win_row, win_col+1) |
| win_p10 | input | 8 | Cache pixel at (win_row+1, win_col) |
| win_p11 | input | 8 | Cache pixel at (win_row+1, win_col+1) |
| best_dy | output | 6 | Vertical half-pel component of the chosen vector |
| best_dx | output | 6 | Horizontal half-pel component of the chosen vector |
| best_sad | output | 16 | SAD of the chosen vector |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
The window-address assertions assume that only in-range vectors ever drive the cache address. They are therefore guarded by the candidate's range flag. The stimulus includes vectors at every range edge so that the extreme rows and columns are reached. The assertions also assume `cur_pix` and the cache pixels are combinational functions of the addresses shown. The bench models both memories as functions of the address presented in the same cycle, and it changes candidate buses only at falling edges.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int CBM_VEC_W = 6;
  localparam int CBM_PIX_W = 8;

  typedef logic signed [CBM_VEC_W-1:0] vec_t;

  typedef struct packed {
    vec_t dy;
    vec_t dx;
  } mv_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } st_t;
endpackage

// File: rtl/cbm_range_chk.sv
module cbm_range_chk
  import cbm_pkg::*;
#(
  parameter int MIN_DY = -12,
  parameter int MAX_DY = 12,
  parameter int MIN_DX = -16,
  parameter int MAX_DX = 14
) (
  input  mv_t  mv,
  output logic ok
);
  always_comb begin
    ok = (int'(mv.dy) >= MIN_DY) && (int'(mv.dy) <= MAX_DY) &&
         (int'(mv.dx) >= MIN_DX) && (int'(mv.dx) <= MAX_DX);
  end
endmodule

// File: rtl/cbm_addr_gen.sv
module cbm_addr_gen
  import cbm_pkg::*;
#(
  parameter int MB_LOG = 4,
  parameter int OFF_Y  = 6,
  parameter int OFF_X  = 8,
  parameter int ROW_W  = 5,
  parameter int COL_W  = 5
) (
  input  logic [MB_LOG-1:0] py,
  input  logic [MB_LOG-1:0] px,
  input  mv_t               mv,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic              frac_y,
  output logic              frac_x
);
  localparam int AW = 10;
  logic signed [AW-1:0] dy_e, dx_e, row_s, col_s;

  always_comb begin
    dy_e   = AW'(mv.dy);
    dx_e   = AW'(mv.dx);
    row_s  = $signed(AW'(py)) + (dy_e >>> 1) + AW'(OFF_Y);
    col_s  = $signed(AW'(px)) + (dx_e >>> 1) + AW'(OFF_X);
    row    = row_s[ROW_W-1:0];
    col    = col_s[COL_W-1:0];
    frac_y = mv.dy[0];
    frac_x = mv.dx[0];
  end
endmodule

// File: rtl/cbm_halfpel.sv
module cbm_halfpel #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] p00,
  input  logic [PIX_W-1:0] p01,
  input  logic [PIX_W-1:0] p10,
  input  logic [PIX_W-1:0] p11,
  input  logic             frac_y,
  input  logic             frac_x,
  output logic [PIX_W-1:0] sample
);
  logic [PIX_W+1:0] s4, s2h, s2v;

  always_comb begin
    s4  = (PIX_W+2)'(p00) + (PIX_W+2)'(p01) + (PIX_W+2)'(p10) + (PIX_W+2)'(p11) + (PIX_W+2)'(2);
    s2h = (PIX_W+2)'(p00) + (PIX_W+2)'(p01) + (PIX_W+2)'(1);
    s2v = (PIX_W+2)'(p00) + (PIX_W+2)'(p10) + (PIX_W+2)'(1);
    unique case ({frac_y, frac_x})
      2'b11:   sample = s4[PIX_W+1:2];
      2'b01:   sample = s2h[PIX_W:1];
      2'b10:   sample = s2v[PIX_W:1];
      default: sample = p00;
    endcase
  end
endmodule

// File: rtl/cand_block_matcher.sv
module cand_block_matcher
  import cbm_pkg::*;
#(
  parameter int N_CAND = 5,
  parameter int MB     = 16,
  parameter int MIN_DY = -12,
  parameter int MAX_DY = 12,
  parameter int MIN_DX = -16,
  parameter int MAX_DX = 14,
  localparam int VW     = CBM_VEC_W,
  localparam int PW     = CBM_PIX_W,
  localparam int MB_LOG = $clog2(MB),
  localparam int NPIX   = MB * MB,
  localparam int PIX_CW = 2 * MB_LOG,
  localparam int OFF_Y  = -(MIN_DY / 2),
  localparam int OFF_X  = -(MIN_DX / 2),
  localparam int WIN_H  = MB + (MAX_DY - MIN_DY) / 2,
  localparam int WIN_W  = MB + (MAX_DX - MIN_DX) / 2,
  localparam int ROW_W  = $clog2(WIN_H),
  localparam int COL_W  = $clog2(WIN_W),
  localparam int SAD_W  = $clog2(NPIX * ((1 << PW) - 1) + 1),
  localparam int IDX_W  = $clog2(N_CAND)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [N_CAND*VW-1:0] cand_dy,
  input  logic [N_CAND*VW-1:0] cand_dx,
  output logic [MB_LOG-1:0]    cur_row,
  output logic [MB_LOG-1:0]    cur_col,
  input  logic [PW-1:0]        cur_pix,
  output logic [ROW_W-1:0]     win_row,
  output logic [COL_W-1:0]     win_col,
  input  logic [PW-1:0]        win_p00,
  input  logic [PW-1:0]        win_p01,
  input  logic [PW-1:0]        win_p10,
  input  logic [PW-1:0]        win_p11,
  output logic [VW-1:0]        best_dy,
  output logic [VW-1:0]        best_dx,
  output logic [SAD_W-1:0]     best_sad,
  output logic                 done
);
  st_t               state_q;
  mv_t               mv_q [N_CAND];
  logic [N_CAND-1:0] ok_q;
  logic [N_CAND-1:0] ok_in;
  mv_t               mv_in [N_CAND];
  logic [IDX_W-1:0]  idx_q;
  logic [PIX_CW-1:0] pix_q;
  logic [SAD_W-1:0]  acc_q;
  logic              have_best_q;
  mv_t               best_q;
  logic [SAD_W-1:0]  best_sad_q;

  logic              run;
  logic              cur_ok;
  mv_t               cur_mv;
  logic              fy, fx;
  logic [PW-1:0]     pred;
  logic [PW-1:0]     absd;
  logic [SAD_W-1:0]  sad_next;
  logic              last_pix;
  logic              last_cand;

  // candidate capture and range screening, one checker per list slot
  for (genvar i = 0; i < N_CAND; i++) begin : g_cand
    assign mv_in[i].dy = vec_t'(cand_dy[i*VW +: VW]);
    assign mv_in[i].dx = vec_t'(cand_dx[i*VW +: VW]);
    cbm_range_chk #(
      .MIN_DY(MIN_DY), .MAX_DY(MAX_DY), .MIN_DX(MIN_DX), .MAX_DX(MAX_DX)
    ) u_rng (
      .mv(mv_in[i]),
      .ok(ok_in[i])
    );
  end

  assign run       = (state_q == ST_RUN);
  assign cur_mv    = mv_q[idx_q];
  assign cur_ok    = ok_q[idx_q];
  assign cur_row   = pix_q[PIX_CW-1:MB_LOG];
  assign cur_col   = pix_q[MB_LOG-1:0];
  assign last_pix  = (pix_q == PIX_CW'(NPIX - 1));
  assign last_cand = (idx_q == IDX_W'(N_CAND - 1));

  cbm_addr_gen #(
    .MB_LOG(MB_LOG), .OFF_Y(OFF_Y), .OFF_X(OFF_X), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_addr (
    .py    (cur_row),
    .px    (cur_col),
    .mv    (cur_mv),
    .row   (win_row),
    .col   (win_col),
    .frac_y(fy),
    .frac_x(fx)
  );

  cbm_halfpel #(.PIX_W(PW)) u_hp (
    .p00   (win_p00),
    .p01   (win_p01),
    .p10   (win_p10),
    .p11   (win_p11),
    .frac_y(fy),
    .frac_x(fx),
    .sample(pred)
  );

  always_comb begin
    absd     = (pred >= cur_pix) ? (pred - cur_pix) : (cur_pix - pred);
    sad_next = acc_q + SAD_W'(absd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ok_q        <= '0;
      idx_q       <= '0;
      pix_q       <= '0;
      acc_q       <= '0;
      have_best_q <= 1'b0;
      best_q      <= '0;
      best_sad_q  <= '0;
      for (int i = 0; i < N_CAND; i++) mv_q[i] <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            for (int i = 0; i < N_CAND; i++) mv_q[i] <= mv_in[i];
            ok_q        <= ok_in;
            if (ok_in == '0) begin
              mv_q[0] <= '0;
              ok_q[0] <= 1'b1;
            end
            idx_q       <= '0;
            pix_q       <= '0;
            acc_q       <= '0;
            have_best_q <= 1'b0;
            state_q     <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (cur_ok && !last_pix) begin
            acc_q <= sad_next;
            pix_q <= pix_q + 1'b1;
          end else begin
            if (cur_ok && (!have_best_q || sad_next < best_sad_q)) begin
              best_q      <= cur_mv;
              best_sad_q  <= sad_next;
              have_best_q <= 1'b1;
            end
            acc_q <= '0;
            pix_q <= '0;
            if (last_cand) state_q <= ST_DONE;
            else           idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done     = (state_q == ST_DONE);
  assign best_dy  = best_q.dy;
  assign best_dx  = best_q.dx;
  assign best_sad = best_sad_q;
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int ROW_W = 5,
  parameter int COL_W = 5,
  parameter int WIN_H = 28,
  parameter int WIN_W = 31,
  parameter int SAD_W = 16,
  parameter int VW    = 6,
  parameter int MAXS  = 65280
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             run,
  input logic             cur_ok,
  input logic [ROW_W-1:0] win_row,
  input logic [COL_W-1:0] win_col,
  input logic [VW-1:0]    best_dy,
  input logic [VW-1:0]    best_dx,
  input logic [SAD_W-1:0] best_sad
);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_follows_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(run));

  p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(best_dy) && $stable(best_dx) && $stable(best_sad)));

  p_row_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cur_ok) |-> (int'(win_row) <= WIN_H - 1));

  p_col_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cur_ok) |-> (int'(win_col) <= WIN_W - 1));

  p_sad_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(best_sad) <= MAXS);
endmodule

bind cand_block_matcher cbm_checker #(
  .ROW_W(ROW_W), .COL_W(COL_W), .WIN_H(WIN_H), .WIN_W(WIN_W),
  .SAD_W(SAD_W), .VW(VW), .MAXS(NPIX * ((1 << PW) - 1))
) u_cbm_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .done    (done),
  .run     (run),
  .cur_ok  (cur_ok),
  .win_row (win_row),
  .win_col (win_col),
  .best_dy (best_dy),
  .best_dx (best_dx),
  .best_sad(best_sad)
);

// File: tb/cand_block_matcher_tb.sv
module cand_block_matcher_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [29:0]   cand_dy = '0, cand_dx = '0;
  logic [3:0]    cur_row, cur_col;
  logic [7:0]    cur_pix;
  logic [4:0]    win_row, win_col;
  logic [7:0]    win_p00, win_p01, win_p10, win_p11;
  logic [5:0]    best_dy, best_dx;
  logic [15:0]   best_sad;
  logic          done;

  int checks = 0;
  int failures = 0;
  int sy = 0, sx = 0;
  bit flat = 0;
  int cdy [NC];
  int cdx [NC];
  int e_dy, e_dx, e_sad;
  int done_cnt;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cand_block_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cand_dy(cand_dy), .cand_dx(cand_dx),
    .cur_row(cur_row), .cur_col(cur_col), .cur_pix(cur_pix),
    .win_row(win_row), .win_col(win_col),
    .win_p00(win_p00), .win_p01(win_p01), .win_p10(win_p10), .win_p11(win_p11),
    .best_dy(best_dy), .best_dx(best_dx), .best_sad(best_sad), .done(done)
  );

  function automatic int pat(int r, int c);
    if (flat) return 100;
    return (r * r * 3 + c * 17 + r * c * 5 + 41) & 255;
  endfunction

  function automatic int refpix(int row, int col);
    return pat(row - 6, col - 8);
  endfunction

  function automatic int curpix(int py, int px);
    return pat(py + sy, px + sx);
  endfunction

  // memory models: combinational reads
  always_comb begin
    cur_pix = 8'(curpix(int'(cur_row), int'(cur_col)));
    win_p00 = 8'(refpix(int'(win_row),     int'(win_col)));
    win_p01 = 8'(refpix(int'(win_row),     int'(win_col) + 1));
    win_p10 = 8'(refpix(int'(win_row) + 1, int'(win_col)));
    win_p11 = 8'(refpix(int'(win_row) + 1, int'(win_col) + 1));
  end

  function automatic bit in_range(int dy, int dx);
    return dy >= -12 && dy <= 12 && dx >= -16 && dx <= 14;
  endfunction

  // R5 and R8 expected sample
  function automatic int pred(int py, int px, int dy, int dx);
    int r, c, a, b, d, e;
    r = py + (dy >>> 1) + 6;
    c = px + (dx >>> 1) + 8;
    a = refpix(r, c); b = refpix(r, c + 1);
    d = refpix(r + 1, c); e = refpix(r + 1, c + 1);
    if ((dy & 1) && (dx & 1)) return (a + b + d + e + 2) >> 2;
    if (dx & 1) return (a + b + 1) >> 1;
    if (dy & 1) return (a + d + 1) >> 1;
    return a;
  endfunction

  function automatic int sad_of(int dy, int dx);
    int s = 0;
    for (int py = 0; py < 16; py++)
      for (int px = 0; px < 16; px++) begin
        int p = pred(py, px, dy, dx);
        int q = curpix(py, px);
        s += (p > q) ? p - q : q - p;
      end
    return s;
  endfunction

  // R1 R2 R3 R4 reference selection
  task automatic compute_expected();
    bit any = 0;
    for (int i = 0; i < NC; i++) begin
      if (in_range(cdy[i], cdx[i])) begin
        int s = sad_of(cdy[i], cdx[i]);
        if (!any || s < e_sad) begin
          e_sad = s; e_dy = cdy[i]; e_dx = cdx[i];
        end
        any = 1;
      end
    end
    if (!any) begin
      e_dy = 0; e_dx = 0; e_sad = sad_of(0, 0);
    end
  endtask

  task automatic check(string req, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic load_cands();
    for (int i = 0; i < NC; i++) begin
      cand_dy[i*6 +: 6] = 6'(cdy[i]);
      cand_dx[i*6 +: 6] = 6'(cdx[i]);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int n = 0; n < 8000; n++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic run_and_check(string req);
    bit ok;
    compute_expected();
    load_cands();
    pulse_start();
    wait_done(ok);
    check({req, " done seen"}, int'(ok), 1);
    @(negedge clk);
    check({req, " done one cycle R6"}, int'(done), 0);
    check({req, " best_dy"}, int'($signed(best_dy)), e_dy);
    check({req, " best_dx"}, int'($signed(best_dx)), e_dx);
    check({req, " best_sad"}, int'(best_sad), e_sad);
  endtask

  task automatic set5(int a0, int b0, int a1, int b1, int a2, int b2,
                      int a3, int b3, int a4, int b4);
    cdy[0] = a0; cdx[0] = b0; cdy[1] = a1; cdx[1] = b1;
    cdy[2] = a2; cdx[2] = b2; cdy[3] = a3; cdx[3] = b3;
    cdy[4] = a4; cdx[4] = b4;
  endtask

  task automatic t_reset();
    check("R7 done", int'(done), 0);
    check("R7 best_dy", int'(best_dy), 0);
    check("R7 best_dx", int'(best_dx), 0);
    check("R7 best_sad", int'(best_sad), 0);
  endtask

  task automatic t_integer_best();
    flat = 0; sy = 2; sx = -3;
    set5(0, 0, 4, -6, 2, 2, -4, 8, 1, 1);
    run_and_check("R1 integer");
    check("R1 exact match sad", int'(best_sad), 0);
  endtask

  task automatic t_halfpel();
    flat = 0; sy = 1; sx = 1;
    set5(1, 0, 0, 1, 3, 3, -3, -5, 11, 13);
    run_and_check("R5 halfpel");
    sy = -3; sx = 4;
    set5(12, 14, -12, -16, -11, 13, 12, -15, -5, 9);
    run_and_check("R8 window edges");
  endtask

  task automatic t_out_of_range();
    flat = 0; sy = 0; sx = 0;
    set5(13, 0, 0, 15, 6, 5, -13, 0, 0, -17);
    run_and_check("R2 skip");
    check("R2 chosen slot", int'($signed(best_dy)), 6);
  endtask

  task automatic t_all_invalid();
    flat = 0; sy = 1; sx = 2;
    set5(13, 0, -13, 0, 0, 15, 0, -17, 20, 20);
    run_and_check("R3 zero fallback");
  endtask

  task automatic t_tie();
    flat = 1; sy = 0; sx = 0;
    set5(3, 2, -4, 6, 3, 2, 1, 1, 0, 0);
    run_and_check("R4 tie first");
    check("R4 first dx", int'($signed(best_dx)), 2);
    set5(14, 0, 5, -7, 1, 1, 0, 0, 2, 2);
    run_and_check("R4 tie after skip");
    check("R4 second dy", int'($signed(best_dy)), 5);
    flat = 0;
  endtask

  task automatic t_start_ignored();
    bit ok;
    flat = 0; sy = 2; sx = 1;
    set5(4, 2, 0, 0, -2, -2, 3, 3, 1, -1);
    compute_expected();
    load_cands();
    pulse_start();
    repeat (100) @(negedge clk);
    set5(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    load_cands();
    pulse_start();
    wait_done(ok);
    check("R9 done seen", int'(ok), 1);
    @(negedge clk);
    check("R9 best_dy", int'($signed(best_dy)), e_dy);
    check("R9 best_dx", int'($signed(best_dx)), e_dx);
    check("R9 best_sad", int'(best_sad), e_sad);
    done_cnt = 0;
    for (int n = 0; n < 1500; n++) begin
      @(negedge clk);
      if (done) done_cnt++;
    end
    check("R9 no second search", done_cnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_integer_best();
    t_halfpel();
    t_out_of_range();
    t_all_invalid();
    t_tie();
    t_start_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule